// File: doc/BRIEF.md
# Serial Byte-Memory Slave Controller

This block is the serial-side controller of an 8192-byte nonvolatile memory. A host talks to it over a four-wire serial link in clock mode 0. The link has an active-low select, a serial clock, a data input and a data output with its own drive enable. Each selection carries one command byte, and for array commands a 16-bit address and then a burst of data bytes. The controller runs a byte-wide synchronous memory port. A write presents address and data for one cycle. A read presents an address and expects the byte one cycle later.

All link pins are brought into the system clock domain through a synchronizer chain and handled as sampled levels. Serial-clock edges and select edges are found from those sampled levels. An active-low pause input can freeze a transfer at any bit boundary, and the transfer then continues from the same bit. A write-enable latch guards every array write and every status write. An active-low protect input additionally locks the status register, but it does not block array writes.

Top module: `serial_nvm_slave`

## Requirements
- R1: While select is high, serial-clock and data-input activity has no effect, the data output is not driven and no memory access is issued.
- R2: A command byte is taken only as the first byte after a falling select edge; bytes that follow a completed command in the same selection are ignored.
- R3: Input bits are taken on rising serial-clock edges and output bits change after falling edges, most significant bit first in both directions.
- R4: The serial clock may stay low for any length of time inside a byte without loss of transfer state.
- R5: While the pause input is low, serial-clock and select transitions are ignored and the output is not driven; when the pause input returns high, the transfer resumes at the same bit.
- R6: The controller reads the pause input only while the sampled serial clock is low; a change made while the clock is high takes effect at the next low phase.
- R7: With the protect input low, a status write leaves the status register unchanged; array writes are not affected by this input.
- R8: The output is driven only while a read or status-read command is shifting data out, from the first falling edge of its data phase until deselection.
- R9: Command codes are 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read array and 0x02 write array. Array commands carry a 16-bit address, high byte first, of which the top 3 bits are ignored. Any other code does nothing.
- R10: The status byte reads as bits 7:2 = six user bits written by status write, bit 1 = write-enable latch, bit 0 = 0. The latch is set by 0x06 and cleared by 0x04, and it is cleared when select rises after a write-array or write-status command. Array and status writes are refused while the latch is clear. After reset the status byte is 0x00.
- R11: Within a burst the address advances by one after each byte and wraps from 0x1FFF to 0x0000.
- R12: The memory port never requests a read and a write in the same cycle, and a write strobe lasts exactly one cycle per accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all link pins are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low status-register lock |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for the serial output pad |
| mem_addr | output | 13 | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | One-cycle array write strobe |
| mem_re | output | 1 | Array read request; data expected on the next cycle |
| mem_rdata | input | 8 | Array read data |

## Verification
A bit counter out of step with the host shows up at the very next command: bytes are decoded at the wrong boundary, so a status read returns a shifted value and read bursts return bytes from the wrong address. A bad write-enable latch shows on the next status read, and it also shows as array bytes that change, or fail to change, when read back in a later burst. A wrong pause state shows within one serial-clock phase, either as the output enable dropping while it should stay up or as a bit lost across the pause. An address counter that does not wrap shows on the first read burst that crosses 0x1FFF.

// File: rtl/snv_pkg.sv
package snv_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_SET_WEL = 8'h06;
    localparam logic [BYTE_W-1:0] OP_CLR_WEL = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RD_STAT = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WR_STAT = 8'h01;
    localparam logic [BYTE_W-1:0] OP_RD_ARR  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WR_ARR  = 8'h02;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADR,
        PH_WDAT,
        PH_RDAT,
        PH_SWR,
        PH_SRD
    } phase_e;

    typedef struct packed {
        logic held;
        logic sel;
        logic sck;
    } link_t;

endpackage

// File: rtl/snv_pin_sync.sv
module snv_pin_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_q, stg_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stg_d[0] = d_i;
        end else begin : g_chain
            always_comb stg_d = {stg_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/snv_link_ctl.sv
module snv_link_ctl
    import snv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic sel,
    output logic held,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_start,
    output logic sel_end
);

    link_t q, d;

    always_comb begin
        d = q;
        // pause pin is only looked at during the low clock phase
        d.held = sck_s ? q.held : ~hold_n_s;
        if (!q.held) begin
            d.sel = ~cs_n_s;
            d.sck = sck_s;
        end
        sck_rise  = !q.held && q.sel && sck_s && !q.sck;
        sck_fall  = !q.held && q.sel && !sck_s && q.sck;
        sel_start = !q.held && !q.sel && !cs_n_s;
        sel_end   = !q.held && q.sel && cs_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sel  = q.sel;
    assign held = q.held;

    // R6: the pause state only moves after a low sampled clock
    a_r6_hold_only_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.held) |-> !$past(sck_s));

    // R5: select level is frozen while paused
    a_r5_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        q.held |=> $stable(q.sel));

endmodule

// File: rtl/snv_cmd_engine.sv
module snv_cmd_engine
    import snv_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sel,
    input  logic              sel_start,
    input  logic              sel_end,
    input  logic              held,
    input  logic              si,
    input  logic              wp_n,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re
);

    localparam int USER_W    = BYTE_W - 2;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int HI_W      = ADDR_W - BYTE_W;
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e              phase;
        logic                rd_cmd;
        logic                adr_hi_done;
        logic [BIT_CNT_W-1:0] bit_cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [ADDR_W-1:0]   addr;
        logic [HI_W-1:0]     adr_hi;
        logic                wel;
        logic [USER_W-1:0]   user;
        logic                wr_seen;
        logic [BYTE_W-1:0]   obuf;
        logic                out_act;
        logic                so;
        logic                mem_we;
        logic                mem_re;
        logic                re_dly;
        logic [ADDR_W-1:0]   mem_addr;
        logic [BYTE_W-1:0]   mem_wdata;
    } eng_t;

    eng_t q, d;

    logic [BYTE_W-1:0] byte_in;
    logic [BYTE_W-1:0] status;
    logic [ADDR_W-1:0] new_addr;
    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        d          = q;
        d.mem_we   = 1'b0;
        d.mem_re   = 1'b0;
        d.re_dly   = q.mem_re;
        byte_in    = {q.shreg[BYTE_W-2:0], si};
        status     = {q.user, q.wel, 1'b0};
        new_addr   = {q.adr_hi, byte_in};
        addr_nx    = q.addr + ADDR_W'(1);

        if (q.re_dly) begin
            d.obuf = mem_rdata;
        end

        if (sel_start) begin
            d.phase       = PH_OPC;
            d.bit_cnt     = '0;
            d.adr_hi_done = 1'b0;
            d.wr_seen     = 1'b0;
            d.out_act     = 1'b0;
        end

        if (sel_end) begin
            d.phase   = PH_IDLE;
            d.out_act = 1'b0;
            if (q.wr_seen) begin
                d.wel = 1'b0;
            end
        end

        if (sck_rise) begin
            d.shreg   = byte_in;
            d.bit_cnt = q.bit_cnt + BIT_CNT_W'(1);
            if (q.bit_cnt == LAST_BIT) begin
                case (q.phase)
                    PH_OPC: begin
                        case (byte_in)
                            OP_SET_WEL: begin
                                d.wel   = 1'b1;
                                d.phase = PH_IDLE;
                            end
                            OP_CLR_WEL: begin
                                d.wel   = 1'b0;
                                d.phase = PH_IDLE;
                            end
                            OP_RD_STAT: begin
                                d.obuf  = status;
                                d.phase = PH_SRD;
                            end
                            OP_WR_STAT: begin
                                d.wr_seen = 1'b1;
                                d.phase   = PH_SWR;
                            end
                            OP_RD_ARR: begin
                                d.rd_cmd = 1'b1;
                                d.phase  = PH_ADR;
                            end
                            OP_WR_ARR: begin
                                d.rd_cmd  = 1'b0;
                                d.wr_seen = 1'b1;
                                d.phase   = PH_ADR;
                            end
                            default: d.phase = PH_IDLE;
                        endcase
                    end
                    PH_ADR: begin
                        if (!q.adr_hi_done) begin
                            d.adr_hi      = byte_in[HI_W-1:0];
                            d.adr_hi_done = 1'b1;
                        end else begin
                            d.addr = new_addr;
                            if (q.rd_cmd) begin
                                d.mem_re   = 1'b1;
                                d.mem_addr = new_addr;
                                d.phase    = PH_RDAT;
                            end else begin
                                d.phase = PH_WDAT;
                            end
                        end
                    end
                    PH_WDAT: begin
                        if (q.wel) begin
                            d.mem_we    = 1'b1;
                            d.mem_addr  = q.addr;
                            d.mem_wdata = byte_in;
                        end
                        d.addr = addr_nx;
                    end
                    PH_RDAT: begin
                        d.addr     = addr_nx;
                        d.mem_re   = 1'b1;
                        d.mem_addr = addr_nx;
                    end
                    PH_SWR: begin
                        if (q.wel && wp_n) begin
                            d.user = byte_in[BYTE_W-1:2];
                        end
                        d.phase = PH_IDLE;
                    end
                    PH_SRD: begin
                        d.obuf = status;
                    end
                    default: ;
                endcase
            end
        end

        if (sck_fall && (q.phase == PH_RDAT || q.phase == PH_SRD)) begin
            d.so      = q.obuf[BYTE_W-1];
            d.obuf    = {q.obuf[BYTE_W-2:0], 1'b0};
            d.out_act = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign so        = q.so;
    assign so_oe     = q.out_act && sel && !held;
    assign mem_addr  = q.mem_addr;
    assign mem_wdata = q.mem_wdata;
    assign mem_we    = q.mem_we;
    assign mem_re    = q.mem_re;

    // R7: a low lock input keeps the user status bits unchanged
    a_r7_wp_blocks_status: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> $stable(q.user));

    // R10: array strobe only with the latch set the cycle before
    a_r10_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        q.mem_we |-> $past(q.wel));

    // R5: no progress of the transfer while paused
    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(q.bit_cnt) && $stable(q.phase) && $stable(q.addr)));

    // R8: output drive only in a data-out phase
    a_r8_so_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (q.phase == PH_RDAT || q.phase == PH_SRD));

    // R12: never read and write together
    a_r12_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.mem_we, q.mem_re}));

    // R12: write strobe is a single-cycle pulse
    a_r12_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.mem_we |=> !q.mem_we);

    // R1: memory accesses only follow activity inside a selection
    a_r1_access_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mem_we || q.mem_re) |-> $past(sel));

endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
    import snv_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    input  logic              wp_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata
);

    localparam int PIN_W = 5;
    localparam logic [PIN_W-1:0] PIN_RST = 5'b11001;

    logic [PIN_W-1:0] pins_s;
    logic cs_n_s, sck_s, si_s, hold_n_s, wp_n_s;
    logic sel, held, sck_rise, sck_fall, sel_start, sel_end;

    snv_pin_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wp_n, hold_n, si, sck, cs_n}),
        .q_o   (pins_s)
    );

    assign {wp_n_s, hold_n_s, si_s, sck_s, cs_n_s} = pins_s;

    snv_link_ctl u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sck_s     (sck_s),
        .hold_n_s  (hold_n_s),
        .sel       (sel),
        .held      (held),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sel_start (sel_start),
        .sel_end   (sel_end)
    );

    snv_cmd_engine #(
        .ADDR_W (ADDR_W)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sel       (sel),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .held      (held),
        .si        (si_s),
        .wp_n      (wp_n_s),
        .mem_rdata (mem_rdata),
        .so        (so),
        .so_oe     (so_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

endmodule

// File: tb/sim_serial_nvm_slave.sv
`timescale 1ns/1ps
module sim_serial_nvm_slave;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe, mem_we, mem_re;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    int  n_chk = 0, n_bad = 0;
    bit  done_flag = 1'b0;
    bit  use_pause = 1'b0;
    bit  exp_wel = 1'b0;
    logic [5:0] exp_user = 6'h00;
    logic [7:0] wbuf [16];

    logic [7:0] marr  [int];
    logic [7:0] ref_m [int];

    always #5 clk = ~clk;

    serial_nvm_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // array model behind the memory port
    always @(posedge clk) begin
        if (mem_we) marr[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 8'h00;
    end

    function automatic logic [7:0] ref_rd(int a);
        return ref_m.exists(a) ? ref_m[a] : 8'h00;
    endfunction

    function automatic int wrap_idx(logic [15:0] a16, int i);
        return (int'(a16[12:0]) + i) % 8192;
    endfunction

    function automatic logic [7:0] exp_status();
        return {exp_user, exp_wel, 1'b0};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic got, output logic oe);
        si = b;
        wait_clk(H);
        got = so;
        oe  = so_oe;
        sck = 1'b1;
        wait_clk(H);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit any_oe, output bit all_oe);
        logic g, o;
        any_oe = 1'b0;
        all_oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            if (use_pause && ($urandom % 8 == 0)) wait_clk(20 + int'($urandom % 60));
            bit_x(tx[i], g, o);
            rx[i]  = g;
            any_oe = any_oe | o;
            all_oe = all_oe & o;
        end
    endtask

    task automatic sel_on();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic sel_off();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(H);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] rx;
        bit a, b;
        sel_on();
        xfer(op, rx, a, b);
        sel_off();
        if (op == 8'h06) exp_wel = 1'b1;
        if (op == 8'h04) exp_wel = 1'b0;
    endtask

    task automatic rdsr_chk(input string req);
        logic [7:0] rx;
        bit a, b;
        sel_on();
        xfer(8'h05, rx, a, b);
        check(!a, "R8 no drive during command byte", a, 0);
        xfer(8'h00, rx, a, b);
        check(b, "R8 drive during status byte", b, 1);
        check(rx == exp_status(), req, rx, exp_status());
        sel_off();
        check(so_oe == 1'b0, "R1 off after deselect", so_oe, 0);
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] rx;
        bit a, b;
        sel_on();
        xfer(8'h01, rx, a, b);
        xfer(v, rx, a, b);
        sel_off();
        if (exp_wel && wp_n) exp_user = v[7:2];
        exp_wel = 1'b0;
    endtask

    task automatic wr_burst(input logic [15:0] a16, input int n);
        logic [7:0] rx;
        bit a, b;
        sel_on();
        xfer(8'h02, rx, a, b);
        xfer(a16[15:8], rx, a, b);
        xfer(a16[7:0], rx, a, b);
        for (int i = 0; i < n; i++) begin
            xfer(wbuf[i], rx, a, b);
            if (exp_wel) ref_m[wrap_idx(a16, i)] = wbuf[i];
        end
        sel_off();
        exp_wel = 1'b0;
    endtask

    task automatic rd_burst(input logic [15:0] a16, input int n, input string req);
        logic [7:0] rx;
        bit a, b, any_cmd;
        sel_on();
        xfer(8'h03, rx, a, b);
        any_cmd = a;
        xfer(a16[15:8], rx, a, b);
        any_cmd = any_cmd | a;
        xfer(a16[7:0], rx, a, b);
        any_cmd = any_cmd | a;
        check(!any_cmd, "R8 no drive before data phase", any_cmd, 0);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, rx, a, b);
            check(rx == ref_rd(wrap_idx(a16, i)), req, rx, ref_rd(wrap_idx(a16, i)));
            check(b, "R8 drive during read data", b, 1);
        end
        sel_off();
        check(so_oe == 1'b0, "R1 off after deselect", so_oe, 0);
    endtask

    task automatic start_read(input logic [15:0] a16);
        logic [7:0] rx;
        bit a, b;
        sel_on();
        xfer(8'h03, rx, a, b);
        xfer(a16[15:8], rx, a, b);
        xfer(a16[7:0], rx, a, b);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rx;
        logic g, o;
        bit a, b;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1234_5EED);

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // reset state
        check(so_oe == 1'b0, "R8 reset drive", so_oe, 0);
        check(mem_we == 1'b0 && mem_re == 1'b0, "R12 reset port idle", {mem_we, mem_re}, 0);
        rdsr_chk("R10 reset status");

        // writes refused without latch
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        wr_burst(16'h0010, 2);
        rd_burst(16'h0010, 2, "R10 write refused with latch clear");

        // latch set / clear
        cmd(8'h06);
        rdsr_chk("R10 latch set");
        cmd(8'h04);
        rdsr_chk("R10 latch cleared");
        cmd(8'h06);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        wr_burst(16'h0010, 3);
        rdsr_chk("R10 latch cleared after write");
        rd_burst(16'h0010, 3, "R11 burst write and read");

        // R2: second byte in same selection ignored
        sel_on();
        xfer(8'h06, rx, a, b);
        xfer(8'h04, rx, a, b);
        sel_off();
        exp_wel = 1'b1;
        rdsr_chk("R2 trailing opcode ignored");
        cmd(8'h04);

        // R1: activity while deselected
        a = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'(8'h06 >> i), g, o);
            a = a | o;
        end
        check(!a, "R1 no drive while deselected", a, 0);
        rdsr_chk("R1 deselected bits ignored");

        // R9: unknown code, ignored address bits
        cmd(8'hAB);
        rdsr_chk("R9 unknown code no effect");
        cmd(8'h06);
        wbuf[0] = 8'h5A;
        wr_burst(16'hE005, 1);
        rd_burst(16'h0005, 1, "R9 top address bits ignored");

        // R11: wrap across the top
        cmd(8'h06);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        wr_burst(16'h1FFE, 4);
        rd_burst(16'h1FFF, 3, "R11 address wrap");
        rd_burst(16'h0000, 2, "R11 wrapped bytes at zero");

        // R7: lock input
        wp_n = 1'b0;
        cmd(8'h06);
        wrsr(8'hFC);
        rdsr_chk("R7 status locked");
        cmd(8'h06);
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        wr_burst(16'h0100, 2);
        rd_burst(16'h0100, 2, "R7 array write with lock low");
        wp_n = 1'b1;
        cmd(8'h06);
        wrsr(8'hA8);
        rdsr_chk("R10 status user bits written");

        // data for pause tests
        cmd(8'h06);
        wbuf[0] = 8'hC3; wbuf[1] = 8'h5A;
        wr_burst(16'h0200, 2);

        // R5: pause mid byte, clock and select toggles ignored
        start_read(16'h0200);
        for (int i = 7; i >= 5; i--) begin
            bit_x(1'b0, g, o);
            rx[i] = g;
        end
        hold_n = 1'b0;
        wait_clk(H);
        check(so_oe == 1'b0, "R5 output off while paused", so_oe, 0);
        sck = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H);
        sck = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H);
        cs_n = 1'b1; wait_clk(H); cs_n = 1'b0; wait_clk(H);
        check(so_oe == 1'b0, "R5 still off after toggles", so_oe, 0);
        hold_n = 1'b1;
        wait_clk(H);
        check(so_oe == 1'b1, "R5 drive back after pause", so_oe, 1);
        for (int i = 4; i >= 0; i--) begin
            bit_x(1'b0, g, o);
            rx[i] = g;
        end
        check(rx == 8'hC3, "R5 byte resumes at same bit", rx, 8'hC3);
        xfer(8'h00, rx, a, b);
        check(rx == 8'h5A, "R5 burst continues", rx, 8'h5A);
        sel_off();

        // R6: pause change while clock high
        start_read(16'h0200);
        for (int i = 7; i >= 4; i--) begin
            bit_x(1'b0, g, o);
            rx[i] = g;
        end
        si = 1'b0;
        wait_clk(H);
        rx[3] = so;
        sck = 1'b1;
        wait_clk(2);
        hold_n = 1'b0;
        wait_clk(H);
        check(so_oe == 1'b1, "R6 pause not taken while clock high", so_oe, 1);
        sck = 1'b0;
        wait_clk(H);
        check(so_oe == 1'b0, "R6 pause taken at low phase", so_oe, 0);
        hold_n = 1'b1;
        wait_clk(H);
        check(so_oe == 1'b1, "R6 resume", so_oe, 1);
        for (int i = 2; i >= 0; i--) begin
            bit_x(1'b0, g, o);
            rx[i] = g;
        end
        check(rx == 8'hC3, "R6 byte intact across pause", rx, 8'hC3);
        sel_off();

        // random mix with clock stalls (R4, R3)
        use_pause = 1'b1;
        for (int it = 0; it < 24; it++) begin
            int k, n;
            logic [15:0] a16;
            k   = int'($urandom % 4);
            n   = 1 + int'($urandom % 8);
            a16 = 16'($urandom);
            for (int j = 0; j < n; j++) wbuf[j] = 8'($urandom);
            case (k)
                0: begin cmd(8'h06); wr_burst(a16, n); rd_burst(a16, n, "R4 R3 random burst after stalls"); end
                1: begin wr_burst(a16, n); rd_burst(a16, n, "R10 random refused write"); end
                2: rd_burst(a16, n, "R11 random read burst");
                default: begin
                    wp_n = 1'($urandom);
                    if ($urandom % 2 == 0) cmd(8'h06);
                    wrsr(8'($urandom));
                    rdsr_chk("R7 R10 random status write");
                    wp_n = 1'b1;
                end
            endcase
        end
        use_pause = 1'b0;
        rdsr_chk("R10 final status");

        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule